// File: doc/BRIEF.md
# Password-Protected Sectored Serial Memory Slave

This block is a two-wire serial slave with an active-low select input. It fronts a small register-based memory of fourteen sectors, each eight bytes long. The host opens a session with a start condition and a command byte that picks the direction, one of two stored passwords and a sector. The host then sends eight password bytes and one poll byte. The poll byte is acknowledged only if every password byte matched. After that, data moves: a read streams bytes out of the sector from byte 0, and a write collects exactly eight bytes. A write is committed by a timed internal write cycle. That cycle starts at the stop condition.

The serial lines are oversampled by the system clock. Start and stop are detected as data-line edges while the clock line is high. Incoming bits are taken on rising clock-line edges. The slave changes the data line only after falling edges. The open-drain pad is represented by one output that pulls the line low.

There is no streaming interface at the block edge. The serial lines carry all data, so the pins stay plain.

Top module: `sms_slave`

## Requirements
- R1: After a start condition, a command byte is acknowledged when the sector field is valid and no write cycle is running. Command byte layout: bit 7 = 1 selects write and 0 selects read; bit 4 selects password 1 (1) or password 0 (0); bits 3:0 give the sector index; bits 6:5 are ignored. Acknowledge means the slave pulls the line low in the ninth clock slot.
- R2: A command with sector index 14 or 15 is not acknowledged. Every later byte in that session is also not acknowledged, until the next start condition.
- R3: The eight bytes after an accepted command are each acknowledged. They are compared in order with bytes 0..7 of the selected password. Both passwords are all zeros after reset.
- R4: The poll byte that follows the password is acknowledged only if all eight password bytes matched. On a mismatch, the poll byte and everything after it are not acknowledged, and the line is never pulled low, until a new start condition.
- R5: A read sends bytes MSB first, starting at byte 0 of the sector. It continues while the host acknowledges each byte. After byte 7 it wraps to byte 0 of the same sector. A host no-acknowledge ends the read.
- R6: A write acknowledges the first eight data bytes and rejects any further byte. A stop after exactly eight bytes stores them at bytes 0..7 of the sector, in order.
- R7: A stop after fewer than eight write data bytes cancels the write and leaves the memory unchanged. No write cycle is started, so the next command is acknowledged.
- R8: For WR_CYCLES clocks after a committing stop, any command byte is not acknowledged. After that time, commands are accepted and the new data reads back.
- R9: While the select input is high, the slave never pulls the line low and recognises no start condition. Raising the select input in the middle of a write abandons that write without storing it.
- R10: After reset, the line is released and every memory byte reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n_i | input | 1 | Active-low select; high deselects the slave |
| scl_i | input | 1 | Serial clock line from the host |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_low_o | output | 1 | 1 pulls the open-drain data line low |

## Verification
A wrong bit counter or a missed edge shifts the acknowledge slot. The host then sees a high line in the ninth slot of the very first byte, or a corrupted bit in the first byte read back. A password flag that stays set shows up as an acknowledged poll byte after a deliberately wrong password, within one byte time. A faulty write timer or commit path appears either as a command acknowledged while the cycle should still be running, or as stale data on the next read of the sector.

// File: rtl/sms_pkg.sv
package sms_pkg;
  localparam int PW_BYTES = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_PASS,
    PH_POLL,
    PH_RD,
    PH_WR,
    PH_IGN
  } phase_t;
endpackage

// File: rtl/sms_line_watch.sv
module sms_line_watch #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic cs_act,
  output logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic rise_ev,
  output logic fall_ev
);
  logic [SYNC-1:0] scl_q, sda_q, cs_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      cs_q  <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC-2:0], scl_i};
      sda_q <= {sda_q[SYNC-2:0], sda_i};
      cs_q  <= {cs_q[SYNC-2:0], cs_n_i};
      scl_p <= scl_q[SYNC-1];
      sda_p <= sda_q[SYNC-1];
    end
  end

  assign cs_act   = ~cs_q[SYNC-1];
  assign sda_s    = sda_q[SYNC-1];
  assign rise_ev  = scl_q[SYNC-1] & ~scl_p;
  assign fall_ev  = ~scl_q[SYNC-1] & scl_p;
  assign start_ev = scl_q[SYNC-1] & scl_p & sda_p & ~sda_q[SYNC-1];
  assign stop_ev  = scl_q[SYNC-1] & scl_p & ~sda_p & sda_q[SYNC-1];
endmodule

// File: rtl/sms_store.sv
module sms_store #(
  parameter int N_SECT     = 14,
  parameter int SECT_BYTES = 8,
  parameter int WR_CYCLES  = 1000,
  localparam int SW = 4,
  localparam int IW = $clog2(SECT_BYTES),
  localparam int CW = $clog2(WR_CYCLES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SW-1:0]           rd_sect,
  input  logic [IW-1:0]           rd_idx,
  output logic [7:0]              rd_byte,
  input  logic                    pw_sel,
  input  logic [IW-1:0]           pw_idx,
  output logic [7:0]              pw_byte,
  input  logic                    commit,
  input  logic [SW-1:0]           cm_sect,
  input  logic [SECT_BYTES*8-1:0] wbuf,
  output logic                    busy
);
  logic [7:0] mem [N_SECT][SECT_BYTES];
  logic [7:0] pw  [2][sms_pkg::PW_BYTES];
  logic [CW-1:0] tmr;
  logic [SW-1:0] pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tmr  <= '0;
      pend <= '0;
      for (int s = 0; s < N_SECT; s++)
        for (int b = 0; b < SECT_BYTES; b++)
          mem[s][b] <= 8'h00;
      for (int p = 0; p < 2; p++)
        for (int b = 0; b < sms_pkg::PW_BYTES; b++)
          pw[p][b] <= 8'h00;
    end else if (commit && !busy) begin
      busy <= 1'b1;
      tmr  <= '0;
      pend <= cm_sect;
    end else if (busy) begin
      if (tmr == CW'(WR_CYCLES - 1)) begin
        busy <= 1'b0;
        for (int s = 0; s < N_SECT; s++)
          if (pend == SW'(s))
            for (int b = 0; b < SECT_BYTES; b++)
              mem[s][b] <= wbuf[b*8 +: 8];
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    for (int s = 0; s < N_SECT; s++)
      if (rd_sect == SW'(s)) rd_byte = mem[s][rd_idx];
    pw_byte = pw[pw_sel][pw_idx];
  end
endmodule

// File: rtl/sms_ctrl.sv
module sms_ctrl
  import sms_pkg::*;
#(
  parameter int N_SECT     = 14,
  parameter int SECT_BYTES = 8,
  localparam int SW = 4,
  localparam int IW = $clog2(SECT_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_act,
  input  logic                    start_ev,
  input  logic                    stop_ev,
  input  logic                    rise_ev,
  input  logic                    fall_ev,
  input  logic                    sda_s,
  input  logic                    busy,
  input  logic [7:0]              rd_byte,
  input  logic [7:0]              pw_byte,
  output logic                    sda_low,
  output logic [SW-1:0]           sect,
  output logic [IW-1:0]           rptr,
  output logic                    pw_sel,
  output logic [IW-1:0]           pidx,
  output logic                    commit,
  output logic [SECT_BYTES*8-1:0] wbuf,
  output phase_t                  phase,
  output logic                    pw_ok
);
  localparam logic [IW-1:0] LAST_PW = IW'(PW_BYTES - 1);

  logic [3:0]  bitcnt;
  logic        skip_fall;
  logic [7:0]  shreg;
  logic [7:0]  txb;
  logic        dir_wr;
  logic        mnak;
  logic [IW:0] wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE; bitcnt <= '0; skip_fall <= 1'b0; shreg <= '0;
      txb <= '0; dir_wr <= 1'b0; pw_sel <= 1'b0; sect <= '0; pidx <= '0;
      pw_ok <= 1'b0; rptr <= '0; wcnt <= '0; wbuf <= '0; mnak <= 1'b0;
      sda_low <= 1'b0; commit <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (!cs_act) begin
        phase   <= PH_IDLE;
        sda_low <= 1'b0;
      end else if (start_ev) begin
        phase     <= PH_CMD;
        bitcnt    <= '0;
        skip_fall <= 1'b1;
        sda_low   <= 1'b0;
      end else if (stop_ev) begin
        if (phase == PH_WR && wcnt == (IW+1)'(SECT_BYTES)) commit <= 1'b1;
        phase   <= PH_IDLE;
        sda_low <= 1'b0;
      end else if (rise_ev) begin
        if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_s};
        else               mnak  <= sda_s;
      end else if (fall_ev) begin
        if (skip_fall) begin
          skip_fall <= 1'b0;
        end else if (bitcnt < 4'd7) begin
          bitcnt  <= bitcnt + 1'b1;
          txb     <= {txb[6:0], 1'b0};
          sda_low <= (phase == PH_RD) ? ~txb[6] : 1'b0;
        end else if (bitcnt == 4'd7) begin
          bitcnt  <= 4'd8;
          sda_low <= 1'b0;
          case (phase)
            PH_CMD: begin
              if (!busy && ({1'b0, shreg[3:0]} < 5'(N_SECT))) begin
                dir_wr  <= shreg[7];
                pw_sel  <= shreg[4];
                sect    <= shreg[3:0];
                pidx    <= '0;
                pw_ok   <= 1'b1;
                phase   <= PH_PASS;
                sda_low <= 1'b1;
              end else begin
                phase <= PH_IGN;
              end
            end
            PH_PASS: begin
              sda_low <= 1'b1;
              pw_ok   <= pw_ok && (shreg == pw_byte);
              pidx    <= pidx + 1'b1;
              if (pidx == LAST_PW) phase <= PH_POLL;
            end
            PH_POLL: begin
              if (pw_ok) begin
                sda_low <= 1'b1;
                phase   <= dir_wr ? PH_WR : PH_RD;
                rptr    <= '0;
                mnak    <= 1'b0;
                wcnt    <= '0;
              end else begin
                phase <= PH_IGN;
              end
            end
            PH_WR: begin
              if (wcnt < (IW+1)'(SECT_BYTES)) begin
                sda_low <= 1'b1;
                wcnt    <= wcnt + 1'b1;
                for (int k = 0; k < SECT_BYTES; k++)
                  if (wcnt == (IW+1)'(k)) wbuf[k*8 +: 8] <= shreg;
              end
            end
            default: sda_low <= 1'b0;
          endcase
        end else begin
          bitcnt <= '0;
          if (phase == PH_RD && !mnak) begin
            txb     <= rd_byte;
            sda_low <= ~rd_byte[7];
            rptr    <= rptr + 1'b1;
          end else begin
            sda_low <= 1'b0;
            if (phase == PH_RD) phase <= PH_IGN;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sms_slave.sv
module sms_slave
  import sms_pkg::*;
#(
  parameter int N_SECT     = 14,
  parameter int SECT_BYTES = 8,
  parameter int WR_CYCLES  = 1000,
  parameter int SYNC       = 2,
  localparam int SW = 4,
  localparam int IW = $clog2(SECT_BYTES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_low_o
);
  logic cs_act, sda_s, start_ev, stop_ev, rise_ev, fall_ev;
  logic busy, sda_low_q, pw_sel, commit, pw_ok;
  logic [7:0] rd_byte, pw_byte;
  logic [SW-1:0] sect;
  logic [IW-1:0] rptr, pidx;
  logic [SECT_BYTES*8-1:0] wbuf;
  phase_t phase;

  sms_line_watch #(.SYNC(SYNC)) u_watch (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .scl_i(scl_i), .sda_i(sda_i),
    .cs_act(cs_act), .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  sms_ctrl #(.N_SECT(N_SECT), .SECT_BYTES(SECT_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .start_ev(start_ev),
    .stop_ev(stop_ev), .rise_ev(rise_ev), .fall_ev(fall_ev), .sda_s(sda_s),
    .busy(busy), .rd_byte(rd_byte), .pw_byte(pw_byte), .sda_low(sda_low_q),
    .sect(sect), .rptr(rptr), .pw_sel(pw_sel), .pidx(pidx), .commit(commit),
    .wbuf(wbuf), .phase(phase), .pw_ok(pw_ok)
  );

  sms_store #(.N_SECT(N_SECT), .SECT_BYTES(SECT_BYTES), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_sect(sect), .rd_idx(rptr), .rd_byte(rd_byte),
    .pw_sel(pw_sel), .pw_idx(pidx), .pw_byte(pw_byte), .commit(commit),
    .cm_sect(sect), .wbuf(wbuf), .busy(busy)
  );

  assign sda_low_o = sda_low_q & ~cs_n_i;
endmodule

// File: rtl/sms_chk.sv
module sms_chk
  import sms_pkg::*;
#(
  parameter int N_SECT = 14
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n_i,
  input logic       sda_low_q,
  input phase_t     phase,
  input logic       pw_ok,
  input logic [3:0] sect,
  input logic       commit,
  input logic       busy
);
  // R9
  desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !sda_low_q);

  // R4
  data_needs_pw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RD || phase == PH_WR) |-> pw_ok);

  // R2
  sector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase inside {PH_PASS, PH_POLL, PH_RD, PH_WR}) |-> ({1'b0, sect} < 5'(N_SECT)));

  // R6
  commit_starts_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  // R8
  busy_blocks_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(phase inside {PH_PASS, PH_POLL, PH_RD, PH_WR}));
endmodule

bind sms_slave sms_chk #(.N_SECT(N_SECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sda_low_q(sda_low_q),
  .phase(phase), .pw_ok(pw_ok), .sect(sect), .commit(commit), .busy(busy)
);

// File: tb/tb_sms_slave.sv
`timescale 1ns/1ps
module tb_sms_slave;
  localparam int WRC = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_low;
  logic sda_line;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_low;

  sms_slave #(.WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .scl_i(scl), .sda_i(sda_line),
    .sda_low_o(sda_low)
  );

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'hA5 ^ 8'(i * 8'h13) ^ 8'(s << 4);
  endfunction

  task automatic bstart();
    sda_m = 1'b1; w(4); scl = 1'b1; w(8); sda_m = 1'b0; w(8); scl = 1'b0; w(4);
  endtask

  task automatic bstop();
    sda_m = 1'b0; w(4); scl = 1'b1; w(8); sda_m = 1'b1; w(8);
  endtask

  task automatic send(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(4); scl = 1'b1; w(8); scl = 1'b0; w(4);
    end
    sda_m = 1'b1; w(4); scl = 1'b1; w(4); acked = ~sda_line; w(4); scl = 1'b0; w(4);
  endtask

  task automatic recv(input logic ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(4); scl = 1'b1; w(4); b[i] = sda_line; w(4); scl = 1'b0;
    end
    w(2); sda_m = ~ack; w(2); scl = 1'b1; w(8); scl = 1'b0; w(4); sda_m = 1'b1;
  endtask

  // command + password (all bytes xor pw_err at index 3) + poll; returns poll ack
  task automatic open_sess(input logic [7:0] cmd, input logic [7:0] pw_err,
                           output logic cmd_ack, output logic poll_ack);
    logic a;
    bstart();
    send(cmd, cmd_ack);
    poll_ack = 1'b0;
    if (cmd_ack) begin
      for (int i = 0; i < 8; i++) begin
        send((i == 3) ? pw_err : 8'h00, a);
        chk("R3 password byte ack", 32'(a), 32'd1);
      end
      send(8'h00, poll_ack);
    end
  endtask

  task automatic t_reset();
    logic ca, pa;
    logic [7:0] b;
    chk("R10 line released after reset", 32'(sda_low), 32'd0);
    open_sess(8'h00, 8'h00, ca, pa);
    chk("R10 read cmd ack", 32'(ca), 32'd1);
    recv(1'b0, b);
    chk("R10 memory zero", 32'(b), 32'h00);
    bstop();
  endtask

  task automatic t_write_read();
    logic ca, pa, a;
    logic [7:0] b;
    open_sess(8'h85, 8'h00, ca, pa);
    chk("R1 write cmd ack", 32'(ca), 32'd1);
    chk("R4 poll ack on match", 32'(pa), 32'd1);
    for (int i = 0; i < 8; i++) begin
      send(pat(5, i), a);
      chk("R6 data byte ack", 32'(a), 32'd1);
    end
    send(8'h3C, a);
    chk("R6 ninth byte rejected", 32'(a), 32'd0);
    bstop();
    bstart();
    send(8'h05, a);
    chk("R8 cmd nack while write cycle runs", 32'(a), 32'd0);
    bstop();
    w(WRC + 100);
    open_sess(8'h65, 8'h00, ca, pa);
    chk("R8 cmd ack after write cycle", 32'(ca), 32'd1);
    chk("R1 ignored bits 6:5", 32'(pa), 32'd1);
    for (int i = 0; i < 10; i++) begin
      recv(i != 9, b);
      chk("R5 read data and wrap", 32'(b), 32'(pat(5, i % 8)));
    end
    bstop();
    open_sess(8'h15, 8'h00, ca, pa);
    chk("R3 password 1 selected", 32'(pa), 32'd1);
    recv(1'b1, b);
    chk("R5 read via password 1", 32'(b), 32'(pat(5, 0)));
    recv(1'b0, b);
    chk("R5 second byte", 32'(b), 32'(pat(5, 1)));
    bstop();
  endtask

  task automatic t_bad_sector();
    logic a;
    bstart();
    send(8'h0E, a);
    chk("R2 sector 14 nack", 32'(a), 32'd0);
    send(8'h00, a);
    chk("R2 later byte nack", 32'(a), 32'd0);
    bstop();
    bstart();
    send(8'h8F, a);
    chk("R2 sector 15 nack", 32'(a), 32'd0);
    bstop();
  endtask

  task automatic t_bad_pw();
    logic ca, pa;
    logic [7:0] b;
    open_sess(8'h05, 8'h01, ca, pa);
    chk("R4 poll nack on mismatch", 32'(pa), 32'd0);
    recv(1'b1, b);
    chk("R4 no data after mismatch", 32'(b), 32'hFF);
    bstop();
  endtask

  task automatic t_cancel();
    logic ca, pa, a;
    logic [7:0] b;
    open_sess(8'h82, 8'h00, ca, pa);
    for (int i = 0; i < 5; i++) send(8'h77, a);
    bstop();
    open_sess(8'h02, 8'h00, ca, pa);
    chk("R7 no write cycle after short write", 32'(ca), 32'd1);
    recv(1'b0, b);
    chk("R7 memory unchanged", 32'(b), 32'h00);
    bstop();
  endtask

  task automatic t_cs();
    logic ca, pa, a;
    logic [7:0] b;
    open_sess(8'h87, 8'h00, ca, pa);
    for (int i = 0; i < 8; i++) send(pat(7, i), a);
    cs_n = 1'b1; w(10); scl = 1'b1; sda_m = 1'b1; w(10);
    bstart();
    send(8'h07, a);
    chk("R9 no ack while deselected", 32'(a), 32'd0);
    bstop();
    cs_n = 1'b0; w(10);
    open_sess(8'h07, 8'h00, ca, pa);
    chk("R9 not busy after abandoned write", 32'(ca), 32'd1);
    recv(1'b0, b);
    chk("R9 abandoned write not stored", 32'(b), 32'h00);
    bstop();
  endtask

  initial begin
    w(10);
    rst_n = 1'b1;
    w(5);
    cs_n = 1'b0;
    w(10);
    t_reset();
    t_write_read();
    t_bad_sector();
    t_bad_pw();
    t_cancel();
    t_cs();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule